// File: doc/BRIEF.md
# Corner-Aware Quality Mode Controller

This block sits beside a two-stage transform pipeline (a forward 8x8 transform feeding an inverse transform) and turns requested supply levels into data-path behaviour. For each stage a voltage level is requested: nominal, first scaled or second scaled. A sensed process corner code also arrives. A small programmable mode table, indexed by level and corner, gives two truncation select bits for the inverse transform's output multiplexer. It also gives a mask depth for the forward-stage coefficients. Coefficients that the forward stage cannot guarantee at its scaled level are forced to zero before they reach the inverse stage.

Coefficients arrive as a stream of 8x8 blocks in row order, with a start-of-block strobe on the first coefficient. A new mode is taken only on that strobe, so every block is processed in a single mode. The table is read ahead of the data, so the decode adds no delay on the coefficient path. At the end of every block the controller reports how many coefficients it zeroed.

Top module: `qualityModeCtrl`

## Requirements
- R1: After reset, `selV1` and `selV2` are 0, `outValid` and `countValid` are low, and every table entry holds its default. The default for level L and corner c has mask depth = L, V1 = 1 when L is not 0 or c is 0 or 1, and V2 = 1 when L is 2 or when L is 1 and c is 0.
- R2: A block whose latched mask depth is 1 has the coefficients in columns 5, 6 and 7 of every row (column = position mod 8) output as zero, and the others unchanged. A full block reports 24.
- R3: A block whose latched mask depth is 2 or 3 has every coefficient in columns 1 to 7 output as zero, keeping only column 0. A full block reports 56.
- R4: A block whose latched mask depth is 0 passes every coefficient unchanged and reports 0.
- R5: Table entry address = level*5 + corner. The corner codes are 0 slow-slow, 1 slow-fast, 2 typical, 3 fast-slow and 4 fast-fast; the level codes are 0 nominal, 1 first scaled and 2 second scaled. The mask depth is taken from the entry addressed by the forward level. `selV1` and `selV2` are taken from the entry addressed by the inverse level.
- R6: Level and corner inputs are sampled only on a coefficient that carries `blockStart`. Changes during a block change neither the masking nor `selV1`/`selV2` of that block.
- R7: When `cfgWrEn` is high, the entry at `cfgAddr` is written with `cfgData` = {mask depth[3:2], V2[1], V1[0]}. The new value applies from the next block start, never to a block in progress.
- R8: Each coefficient appears on `outCoef` with `outValid` one cycle after it is accepted. `selV1`/`selV2` update one cycle after the start coefficient. `countValid` pulses for one cycle, one cycle after the 64th coefficient, with the block's masked count.
- R9: A level code of 3 is treated as level 2, and a corner code of 5 to 7 is treated as slow-slow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fwdLevel | input | 2 | Requested level of the forward stage |
| invLevel | input | 2 | Requested level of the inverse stage |
| corner | input | 3 | Sensed process corner code |
| cfgWrEn | input | 1 | Table write enable |
| cfgAddr | input | 4 | Table entry address |
| cfgData | input | 4 | Table entry value {mask depth, V2, V1} |
| coefValid | input | 1 | A coefficient is present on coefIn |
| blockStart | input | 1 | Marks the first coefficient of a block |
| coefIn | input | 12 | Incoming forward-transform coefficient (signed) |
| outValid | output | 1 | outCoef is valid |
| outCoef | output | 12 | Coefficient after masking (signed) |
| selV1 | output | 1 | Inverse-stage select: drop the last adder level |
| selV2 | output | 1 | Inverse-stage select: keep only the first term |
| countValid | output | 1 | blockCount is valid (end of block) |
| blockCount | output | 7 | Coefficients zeroed in the finished block |

## Verification
The assertions assume that `coefValid` is low while reset is applied. They also assume that every block starts with `blockStart` on its first coefficient and carries exactly 64 coefficients. The bench drives only whole 64-coefficient blocks, each opened with the strobe, and holds the stream idle in reset. It sweeps every forward level code, inverse level code and corner code, including the out-of-range ones. Mode changes and table writes are placed in the middle of a block to show the one-mode-per-block rule.

// File: rtl/qmodePkg.sv
package qmodePkg;

  typedef struct packed {
    logic [1:0] maskLvl;
    logic       v2;
    logic       v1;
  } modeEntry_t;

  typedef struct packed {
    logic firstCoef;
    logic lastCoef;
    logic maskThis;
  } strobe_t;

  function automatic modeEntry_t defaultEntry(input int lvl, input int crn);
    modeEntry_t e;
    e.maskLvl = 2'(lvl);
    e.v1      = (lvl != 0) || (crn == 0) || (crn == 1);
    e.v2      = (lvl == 2) || ((lvl == 1) && (crn == 0));
    return e;
  endfunction

endpackage

// File: rtl/modeCtrl.sv
module modeCtrl
  import qmodePkg::*;
#(
  parameter int N_LEVELS  = 3,
  parameter int N_CORNERS = 5,
  parameter int DIM       = 8,
  parameter int KEEP_L1   = 5,
  parameter int KEEP_L2   = 1,
  parameter int LVL_W     = 2,
  parameter int CRN_W     = 3,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LVL_W-1:0]  fwdLevel,
  input  logic [LVL_W-1:0]  invLevel,
  input  logic [CRN_W-1:0]  corner,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  modeEntry_t        cfgData,
  input  logic              coefValid,
  input  logic              blockStart,
  output logic              selV1,
  output logic              selV2,
  output strobe_t           strb
);
  localparam int N_ENTRIES = N_LEVELS * N_CORNERS;
  localparam int POS_W     = $clog2(DIM * DIM);
  localparam int COL_W     = $clog2(DIM);

  modeEntry_t tbl [N_ENTRIES];

  genvar gi;
  generate
    for (gi = 0; gi < N_ENTRIES; gi++) begin : g_entry
      always_ff @(posedge clk) begin
        if (!rstN)
          tbl[gi] <= defaultEntry(gi / N_CORNERS, gi % N_CORNERS);
        else if (cfgWrEn && cfgAddr == ADDR_W'(gi))
          tbl[gi] <= cfgData;
      end
    end
  endgenerate

  logic [LVL_W-1:0]  fwdEff, invEff;
  logic [CRN_W-1:0]  crnEff;
  logic [ADDR_W-1:0] fwdIdx, invIdx;
  modeEntry_t        fwdEnt, invEnt;

  always_comb begin
    fwdEff = (fwdLevel > LVL_W'(N_LEVELS - 1)) ? LVL_W'(N_LEVELS - 1) : fwdLevel;
    invEff = (invLevel > LVL_W'(N_LEVELS - 1)) ? LVL_W'(N_LEVELS - 1) : invLevel;
    crnEff = (corner >= CRN_W'(N_CORNERS)) ? '0 : corner;
    fwdIdx = ADDR_W'(fwdEff) * ADDR_W'(N_CORNERS) + ADDR_W'(crnEff);
    invIdx = ADDR_W'(invEff) * ADDR_W'(N_CORNERS) + ADDR_W'(crnEff);
    fwdEnt = tbl[fwdIdx];
    invEnt = tbl[invIdx];
  end

  logic [POS_W-1:0] pos, curPos;
  logic [1:0]       curMask, effMask;
  logic [COL_W-1:0] col;
  logic             startNow;

  assign startNow = coefValid && blockStart;
  assign curPos   = startNow ? '0 : pos;
  assign effMask  = startNow ? fwdEnt.maskLvl : curMask;
  assign col      = curPos[COL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos     <= '0;
      curMask <= '0;
      selV1   <= 1'b0;
      selV2   <= 1'b0;
    end else begin
      if (coefValid) pos <= curPos + POS_W'(1);
      if (startNow) begin
        curMask <= fwdEnt.maskLvl;
        selV1   <= invEnt.v1;
        selV2   <= invEnt.v2;
      end
    end
  end

  always_comb begin
    strb.firstCoef = startNow;
    strb.lastCoef  = coefValid && (curPos == POS_W'(DIM * DIM - 1));
    strb.maskThis  = coefValid &&
                     ((effMask[1] && col >= COL_W'(KEEP_L2)) ||
                      (effMask == 2'd1 && col >= COL_W'(KEEP_L1)));
  end

endmodule

// File: rtl/maskPath.sv
module maskPath
  import qmodePkg::*;
#(
  parameter int COEF_W = 12,
  parameter int CNT_W  = 7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     coefValid,
  input  logic signed [COEF_W-1:0] coefIn,
  input  strobe_t                  strb,
  output logic                     outValid,
  output logic signed [COEF_W-1:0] outCoef,
  output logic                     countValid,
  output logic [CNT_W-1:0]         blockCount
);
  logic [CNT_W-1:0] runCnt, cntNext;

  assign cntNext = (strb.firstCoef ? '0 : runCnt) + CNT_W'(strb.maskThis);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outCoef    <= '0;
      countValid <= 1'b0;
      blockCount <= '0;
      runCnt     <= '0;
    end else begin
      outValid   <= coefValid;
      countValid <= strb.lastCoef;
      if (coefValid) begin
        outCoef <= strb.maskThis ? '0 : coefIn;
        runCnt  <= cntNext;
      end
      if (strb.lastCoef) blockCount <= cntNext;
    end
  end

endmodule

// File: rtl/qualityModeCtrl.sv
module qualityModeCtrl
  import qmodePkg::*;
#(
  parameter int COEF_W    = 12,
  parameter int N_LEVELS  = 3,
  parameter int N_CORNERS = 5,
  parameter int DIM       = 8,
  parameter int KEEP_L1   = 5,
  parameter int KEEP_L2   = 1,
  parameter int LVL_W     = 2,
  parameter int CRN_W     = 3,
  parameter int ADDR_W    = 4,
  parameter int CNT_W     = 7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [LVL_W-1:0]         fwdLevel,
  input  logic [LVL_W-1:0]         invLevel,
  input  logic [CRN_W-1:0]         corner,
  input  logic                     cfgWrEn,
  input  logic [ADDR_W-1:0]        cfgAddr,
  input  logic [3:0]               cfgData,
  input  logic                     coefValid,
  input  logic                     blockStart,
  input  logic signed [COEF_W-1:0] coefIn,
  output logic                     outValid,
  output logic signed [COEF_W-1:0] outCoef,
  output logic                     selV1,
  output logic                     selV2,
  output logic                     countValid,
  output logic [CNT_W-1:0]         blockCount
);
  strobe_t strb;

  modeCtrl #(
    .N_LEVELS(N_LEVELS), .N_CORNERS(N_CORNERS), .DIM(DIM),
    .KEEP_L1(KEEP_L1), .KEEP_L2(KEEP_L2),
    .LVL_W(LVL_W), .CRN_W(CRN_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .fwdLevel(fwdLevel), .invLevel(invLevel), .corner(corner),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(modeEntry_t'(cfgData)),
    .coefValid(coefValid), .blockStart(blockStart),
    .selV1(selV1), .selV2(selV2), .strb(strb)
  );

  maskPath #(.COEF_W(COEF_W), .CNT_W(CNT_W)) u_path (
    .clk(clk), .rstN(rstN),
    .coefValid(coefValid), .coefIn(coefIn), .strb(strb),
    .outValid(outValid), .outCoef(outCoef),
    .countValid(countValid), .blockCount(blockCount)
  );

endmodule

// File: rtl/qmodeChecker.sv
module qmodeChecker #(
  parameter int COEF_W     = 12,
  parameter int CNT_W      = 7,
  parameter int MAX_MASKED = 56
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     coefValid,
  input logic                     blockStart,
  input logic signed [COEF_W-1:0] coefIn,
  input logic                     maskThis,
  input logic                     outValid,
  input logic signed [COEF_W-1:0] outCoef,
  input logic                     selV1,
  input logic                     selV2,
  input logic                     countValid,
  input logic [CNT_W-1:0]         blockCount
);
  assert_valid_delay_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(coefValid));

  assert_pass_unmasked_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !$past(maskThis) |-> outCoef == $past(coefIn));

  assert_zero_masked_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(maskThis) |-> outCoef == '0);

  assert_sel_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(coefValid && blockStart) |-> $stable({selV1, selV2}));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    countValid |-> blockCount <= CNT_W'(MAX_MASKED));

  assert_count_after_coef_R8: assert property (@(posedge clk) disable iff (!rstN)
    countValid |-> $past(coefValid));
endmodule

bind qualityModeCtrl qmodeChecker #(
  .COEF_W(COEF_W), .CNT_W(CNT_W), .MAX_MASKED(DIM * (DIM - KEEP_L2))
) u_chk (
  .clk(clk), .rstN(rstN), .coefValid(coefValid), .blockStart(blockStart),
  .coefIn(coefIn), .maskThis(strb.maskThis), .outValid(outValid),
  .outCoef(outCoef), .selV1(selV1), .selV2(selV2),
  .countValid(countValid), .blockCount(blockCount)
);

// File: tb/test_qualityModeCtrl.sv
module test_qualityModeCtrl;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rstN;
  logic [1:0]        fwdLevel, invLevel;
  logic [2:0]        corner;
  logic              cfgWrEn;
  logic [3:0]        cfgAddr, cfgData;
  logic              coefValid, blockStart;
  logic signed [11:0] coefIn;
  logic              outValid, selV1, selV2, countValid;
  logic signed [11:0] outCoef;
  logic [6:0]        blockCount;

  int vectors = 0;
  int miscompares = 0;
  logic [3:0] model [15];

  qualityModeCtrl i_qualityModeCtrl (
    .clk(clk), .rstN(rstN), .fwdLevel(fwdLevel), .invLevel(invLevel),
    .corner(corner), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .coefValid(coefValid), .blockStart(blockStart), .coefIn(coefIn),
    .outValid(outValid), .outCoef(outCoef), .selV1(selV1), .selV2(selV2),
    .countValid(countValid), .blockCount(blockCount)
  );

  function automatic logic [3:0] defEnt(int l, int c);
    logic v1, v2;
    v1 = (l != 0) || (c == 0) || (c == 1);
    v2 = (l == 2) || (l == 1 && c == 0);
    return {2'(l), v2, v1};
  endfunction

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // One full block. changeAt: coefficient index at which the level and corner
  // inputs are disturbed (-1 none). wrAt: index at which a table write is issued.
  task automatic runBlock(int fl, int il, int cr, int changeAt,
                          int wrAt, int wrAddr, int wrData, int seed);
    int fe, ie, ce, mlv, masked, val, expv, col;
    logic [3:0] entM, entV;
    bit m;
    string rq;
    fe = (fl > 2) ? 2 : fl;
    ie = (il > 2) ? 2 : il;
    ce = (cr > 4) ? 0 : cr;
    entM = model[fe * 5 + ce];
    entV = model[ie * 5 + ce];
    mlv = entM[3:2];
    masked = 0;
    rq = (mlv == 0) ? "R4" : (mlv == 1) ? "R2" : "R3";
    if (fl > 2 || cr > 4) rq = {rq, "/R9"};
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (k == 0) begin
        fwdLevel = 2'(fl); invLevel = 2'(il); corner = 3'(cr);
      end
      if (k == changeAt) begin
        fwdLevel = 2'(fl ^ 2); invLevel = 2'(il ^ 3); corner = 3'(cr ^ 5);
      end
      cfgWrEn = (k == wrAt);
      cfgAddr = 4'(wrAddr);
      cfgData = 4'(wrData);
      coefValid = 1'b1;
      blockStart = (k == 0);
      val = ((k * 37 + seed * 11) % 1500) + 1;
      if (k % 2 == 1) val = -val;
      coefIn = 12'(val);
      col = k % 8;
      m = (mlv == 1) ? (col >= 5) : (mlv >= 2) ? (col >= 1) : 1'b0;
      expv = m ? 0 : val;
      if (m) masked++;
      @(posedge clk);
      #1;
      check("R8 outValid", int'(outValid), 1);
      check({rq, " outCoef"}, int'(outCoef), expv);
      if (k == 0 || k == 63) begin
        check(k == 0 ? "R5 selV1" : "R6 selV1", int'(selV1), int'(entV[0]));
        check(k == 0 ? "R5 selV2" : "R6 selV2", int'(selV2), int'(entV[1]));
      end
      if (k == 63) begin
        check("R8 countValid", int'(countValid), 1);
        check({rq, " blockCount"}, int'(blockCount), masked);
      end else begin
        check("R8 countValid low", int'(countValid), 0);
      end
    end
    @(negedge clk);
    coefValid = 1'b0; blockStart = 1'b0; cfgWrEn = 1'b0;
    if (wrAt >= 0 && wrAddr < 15) model[wrAddr] = 4'(wrData);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 15; i++) model[i] = defEnt(i / 5, i % 5);
    rstN = 1'b0; fwdLevel = 0; invLevel = 0; corner = 3'd2;
    cfgWrEn = 0; cfgAddr = 0; cfgData = 0;
    coefValid = 0; blockStart = 0; coefIn = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 selV1", int'(selV1), 0);
    check("R1 selV2", int'(selV2), 0);
    check("R1 outValid", int'(outValid), 0);
    check("R1 countValid", int'(countValid), 0);

    // Default table check through a nominal typical block (R1, R4)
    runBlock(0, 0, 2, -1, -1, 0, 0, 1);

    // Sweep of every level and corner code, defaults in place (R1, R2, R3, R5, R9)
    for (int fl = 0; fl < 4; fl++)
      for (int cr = 0; cr < 8; cr++)
        for (int il = 0; il < 4; il++)
          runBlock(fl, il, cr, -1, -1, 0, 0, fl * 32 + cr * 4 + il);

    // R6: mid-block changes of level and corner are not taken
    runBlock(0, 0, 2, 30, -1, 0, 0, 7);
    runBlock(1, 2, 3, 17, -1, 0, 0, 9);

    // R7: a write in the middle of a block leaves that block alone
    runBlock(1, 1, 2, -1, 20, 7, 4'b1001, 3);
    runBlock(1, 1, 2, -1, -1, 0, 0, 4);
    runBlock(0, 2, 4, -1, 5, 14, 4'b0111, 5);
    runBlock(0, 2, 4, -1, -1, 0, 0, 6);
    runBlock(2, 2, 4, -1, -1, 0, 0, 8);

    summary();
    $finish;
  end
endmodule